// File: doc/BRIEF.md
# Quarter-Duty Two-Phase Clock Enable Generator

This block turns a fast system clock into the phase indications of a slower two-phase processor clock. The system clock runs at twice the processor cycle rate, and each cycle in which the advance input is high counts as one processor half-cycle. From a 2-bit position within a four-half-cycle window, the block produces the two processor phases and a processor-cycle parity bit. It also produces two slow phases that run at half the processor cycle rate. All of these outputs come from registers.

The first slow phase is a quarter-duty enable. It is high only in the first phase of even processor cycles. The second slow phase is active-low and three-quarter duty. It goes low only in the first phase of odd processor cycles. Counter reloads and decrements that are gated by these enables therefore never fall in the second processor phase, which is the only phase in which the processor writes registers. Downstream logic uses the outputs as synchronous enables in the same clock domain.

Top module: `clkph_gen`

## Requirements
- R1: When reset is sampled high, on the next clock edge the outputs become phi1_o=1, phi2_o=0, slow_a_o=1, slow_bn_o=1 and cyc_odd_o=0. This is position 0: the first phase of an even processor cycle.
- R2: phi1_o and phi2_o are always complements of each other. Each cycle with adv_i high swaps them.
- R3: Each cycle with adv_i high moves the position forward by one, from 0 to 3 and then back to 0. Over positions 0,1,2,3: phi1_o is 1,0,1,0, slow_a_o is 1,0,0,0, slow_bn_o is 1,1,0,1, and cyc_odd_o is 0,0,1,1.
- R4: slow_a_o is never high while phi2_o is high.
- R5: slow_a_o is high at exactly one position of four. An advance from that position clears it.
- R6: cyc_odd_o toggles on each advance that leaves the second phase (phi2_o high). It holds on each advance that leaves the first phase.
- R7: A cycle with adv_i low leaves all five outputs unchanged.
- R8: Reset applied in the middle of the sequence returns to position 0 on the next edge, and the outputs restart the sequence from there.
- R9: slow_a_o high and slow_bn_o low never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, two ticks per processor cycle |
| rst_i | input | 1 | Synchronous active-high reset |
| adv_i | input | 1 | Advance by one processor half-cycle |
| phi1_o | output | 1 | First processor phase |
| phi2_o | output | 1 | Second processor phase (write phase) |
| slow_a_o | output | 1 | Quarter-duty slow phase, active high |
| slow_bn_o | output | 1 | Three-quarter-duty slow phase, active low |
| cyc_odd_o | output | 1 | Processor-cycle parity |

## Verification
A wrong position in the counter changes the output pattern within one advance. A slip of one position swaps phi1_o and phi2_o. A slip of two positions exchanges the slow phases against cyc_odd_o. Because every output is compared at every step against a position model that is kept separately, a misaligned or stuck counter is visible at the ports on the first advance after it goes wrong. A decode or hold fault is visible in the very cycle it produces a wrong value.

// File: rtl/clkph_pkg.sv
package clkph_pkg;

    localparam int unsigned HALVES = 4;
    localparam int unsigned POS_W  = $clog2(HALVES);

    typedef logic [POS_W-1:0] pos_t;

    typedef struct packed {
        logic phi1;
        logic phi2;
        logic slow_a;
        logic slow_bn;
        logic cyc_odd;
    } phase_set_t;

    // Position 0 is the first phase of an even processor cycle.
    function automatic phase_set_t pos_decode(input pos_t pos);
        phase_set_t r;
        r.phi1    = ~pos[0];
        r.phi2    =  pos[0];
        r.slow_a  = (pos == pos_t'(0));
        r.slow_bn = (pos != pos_t'(2));
        r.cyc_odd =  pos[1];
        return r;
    endfunction

endpackage

// File: rtl/clkph_pos_ctr.sv
module clkph_pos_ctr
    import clkph_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic adv_i,
    output pos_t pos_next_o
);

    pos_t pos_q;

    always_comb begin
        if (rst_i)
            pos_next_o = '0;
        else if (adv_i)
            pos_next_o = pos_q + pos_t'(1);
        else
            pos_next_o = pos_q;
    end

    always_ff @(posedge clk_i) begin
        pos_q <= pos_next_o;
    end

endmodule

// File: rtl/clkph_decode_reg.sv
module clkph_decode_reg
    import clkph_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       adv_i,
    input  pos_t       pos_next_i,
    output phase_set_t ph_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i)
            ph_o <= pos_decode(pos_t'(0));
        else if (adv_i)
            ph_o <= pos_decode(pos_next_i);
    end

endmodule

// File: rtl/clkph_gen.sv
module clkph_gen
    import clkph_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic adv_i,
    output logic phi1_o,
    output logic phi2_o,
    output logic slow_a_o,
    output logic slow_bn_o,
    output logic cyc_odd_o
);

    pos_t       pos_next;
    phase_set_t ph;

    clkph_pos_ctr u_ctr (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .adv_i      (adv_i),
        .pos_next_o (pos_next)
    );

    clkph_decode_reg u_dec (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .adv_i      (adv_i),
        .pos_next_i (pos_next),
        .ph_o       (ph)
    );

    assign phi1_o    = ph.phi1;
    assign phi2_o    = ph.phi2;
    assign slow_a_o  = ph.slow_a;
    assign slow_bn_o = ph.slow_bn;
    assign cyc_odd_o = ph.cyc_odd;

endmodule

// File: rtl/clkph_gen_chk.sv
module clkph_gen_chk (
    input logic clk_i,
    input logic rst_i,
    input logic adv_i,
    input logic phi1_o,
    input logic phi2_o,
    input logic slow_a_o,
    input logic slow_bn_o,
    input logic cyc_odd_o
);

    logic seen_rst;
    always_ff @(posedge clk_i) begin
        if (rst_i) seen_rst <= 1'b1;
        else if (seen_rst !== 1'b1) seen_rst <= 1'b0;
    end

    logic live;
    assign live = (seen_rst === 1'b1) && !rst_i;

    assert_phase_compl_R2: assert property (@(posedge clk_i) disable iff (!live)
        phi1_o != phi2_o);

    assert_adv_swaps_R3: assert property (@(posedge clk_i) disable iff (!live)
        adv_i |=> (phi1_o != $past(phi1_o)));

    assert_slow_a_no_write_R4: assert property (@(posedge clk_i) disable iff (!live)
        slow_a_o |-> !phi2_o);

    assert_slow_a_single_R5: assert property (@(posedge clk_i) disable iff (!live)
        (adv_i && slow_a_o) |=> !slow_a_o);

    assert_odd_toggle_R6: assert property (@(posedge clk_i) disable iff (!live)
        (adv_i && phi2_o) |=> (cyc_odd_o != $past(cyc_odd_o)));

    assert_hold_R7: assert property (@(posedge clk_i) disable iff (!live)
        !adv_i |=> ($stable(phi1_o) && $stable(slow_a_o) && $stable(slow_bn_o) && $stable(cyc_odd_o)));

    assert_slow_excl_R9: assert property (@(posedge clk_i) disable iff (!live)
        slow_a_o |-> slow_bn_o);

endmodule

bind clkph_gen clkph_gen_chk u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .adv_i     (adv_i),
    .phi1_o    (phi1_o),
    .phi2_o    (phi2_o),
    .slow_a_o  (slow_a_o),
    .slow_bn_o (slow_bn_o),
    .cyc_odd_o (cyc_odd_o)
);

// File: tb/clkph_gen_tb_top.sv
`timescale 1ns/1ps
module clkph_gen_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic adv = 1'b0;
    logic phi1, phi2, sa, sbn, odd;

    int checks = 0;
    int errors = 0;
    int pos    = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    clkph_gen dut_i (
        .clk_i     (clk),
        .rst_i     (rst),
        .adv_i     (adv),
        .phi1_o    (phi1),
        .phi2_o    (phi2),
        .slow_a_o  (sa),
        .slow_bn_o (sbn),
        .cyc_odd_o (odd)
    );

    task automatic chk1(input string tag, input string nm, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b (pos %0d)", tag, nm, act, exp, pos);
        end
    endtask

    // Expected outputs come from the position table in the requirements.
    task automatic chk_all(input string tag);
        logic [3:0] ta, tb;
        ta = 4'b0001;
        tb = 4'b1011;
        chk1(tag, "phi1",    phi1, (pos % 2) == 0);
        chk1(tag, "phi2",    phi2, (pos % 2) == 1);
        chk1(tag, "slow_a",  sa,   ta[pos]);
        chk1(tag, "slow_bn", sbn,  tb[pos]);
        chk1(tag, "cyc_odd", odd,  pos >= 2);
    endtask

    // Drive at the falling edge, sample 1 ns after the following rising edge.
    task automatic step(input logic r, input logic a);
        @(negedge clk);
        rst = r;
        adv = a;
        @(posedge clk);
        #1;
        if (r) pos = 0;
        else if (a) pos = (pos + 1) % 4;
    endtask

    task automatic t_reset_state;
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        chk_all("R1");
    endtask

    task automatic t_free_run;
        for (int i = 0; i < 64; i++) begin
            step(1'b0, 1'b1);
            chk_all("R3");
            checks++;
            if (phi1 === phi2) begin errors++; $display("FAIL R2: actual phi1=%b phi2=%b expected complements", phi1, phi2); end
            checks++;
            if (sa && phi2) begin errors++; $display("FAIL R4: actual slow_a=1 phi2=1 expected slow_a=0"); end
            checks++;
            if (sa && !sbn) begin errors++; $display("FAIL R9: actual slow_a=1 slow_bn=0 expected slow_bn=1"); end
        end
    endtask

    task automatic t_duty_count;
        int na = 0, nb = 0, nt = 0;
        for (int i = 0; i < 16; i++) begin
            step(1'b0, 1'b1);
            na += int'(sa);
            nb += int'(!sbn);
            if (i > 0 && odd != odd) nt++;
        end
        chk1("R5", "slow_a count/16 is 4", na == 4, 1'b1);
        chk1("R5", "slow_bn low count/16 is 4", nb == 4, 1'b1);
    endtask

    task automatic t_parity;
        logic prev_odd, prev_phi2;
        for (int i = 0; i < 8; i++) begin
            prev_odd  = odd;
            prev_phi2 = phi2;
            step(1'b0, 1'b1);
            chk1("R6", "cyc_odd", odd, prev_phi2 ? ~prev_odd : prev_odd);
        end
    endtask

    task automatic t_hold;
        logic [4:0] snap;
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 1'b1);
            snap = {phi1, phi2, sa, sbn, odd};
            for (int j = 0; j < 3; j++) begin
                step(1'b0, 1'b0);
                checks++;
                if ({phi1, phi2, sa, sbn, odd} !== snap) begin
                    errors++;
                    $display("FAIL R7: actual=%b expected=%b", {phi1, phi2, sa, sbn, odd}, snap);
                end
            end
            chk_all("R7");
        end
    endtask

    task automatic t_gapped;
        logic [15:0] pat = 16'b1011_0010_1110_0101;
        for (int i = 0; i < 16; i++) begin
            step(1'b0, pat[i]);
            chk_all("R3");
        end
    endtask

    task automatic t_mid_reset;
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        chk_all("R8");
        for (int i = 0; i < 5; i++) begin
            step(1'b0, 1'b1);
            chk_all("R8");
        end
    endtask

    initial begin
        t_reset_state();
        t_free_run();
        t_duty_count();
        t_parity();
        t_hold();
        t_gapped();
        t_mid_reset();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule